// File: doc/BRIEF.md
# Register File with Undo History

This block is a general register file that keeps an undo log so that a pipeline whose operations finish out of order can still present precise state after a fault. Every accepted register write first copies the register's current contents, its index and the sequence tag of the writing instruction into a circular log. A slow operation may fault after a younger, faster one has already overwritten a register. The log then still holds the overwritten value and can put it back.

Issue logic reports completion progress by naming the newest tag whose predecessors are all known to be free of faults. Log entries at or before that tag drop out of the log from its oldest end. When a fault is reported with a tag, the block walks the log from its newest entry to its oldest. For each entry whose tag is the faulting tag or later, it writes the saved value back, one entry per clock. While it walks, it raises a busy flag. Entries that belong to older instructions stay in the log.

Tags wrap modulo 2^TAG_W. Tag `a` counts as "the same as or later than" tag `b` when `(a - b) mod 2^TAG_W` is below 2^(TAG_W-1).

Top module: `hist_regfile`

## Requirements
- R1: After reset, every register reads 0, and `stall` and `busy` are both 0.
- R2: An accepted write of `wr_data` to register `wr_idx` shows up on both read ports, which are combinational, from the cycle after the write edge.
- R3: Each accepted write adds one log entry. With DEPTH entries held (valid entries and the holes left by rollback both count), `stall` is 1.
- R4: A write is ignored when `stall` is 1, or when `exc_en` is 1 in the same cycle.
- R5: `commit_tag` is stored when `commit_en` is 1. Starting the next cycle, the oldest entry leaves the log, one entry per cycle, if it is a hole or if its tag is the same as or earlier than the stored tag. Retired entries are never restored.
- R6: An `exc_en` that arrives while idle, with N>0 entries held, raises `busy` in the following cycle and holds it for exactly N cycles. With an empty log, `busy` stays 0.
- R7: Rollback restores, newest first, every entry whose tag is the same as or later than `exc_tag`. A register written several times therefore returns to its value before the earliest such write.
- R8: Entries with tags earlier than `exc_tag` keep their register values and stay in the log. Restored entries at the newest end are freed, while restored entries behind a kept entry remain as holes until they reach the oldest end.
- R9: While `busy` is 1, `exc_en` is ignored and no entry retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write request |
| wr_idx | input | 5 | Register to write |
| wr_data | input | 32 | Value to write |
| wr_tag | input | 4 | Sequence tag of the writing instruction |
| rd0_idx | input | 5 | Read port 0 register |
| rd0_data | output | 32 | Read port 0 value |
| rd1_idx | input | 5 | Read port 1 register |
| rd1_data | output | 32 | Read port 1 value |
| commit_en | input | 1 | Completion report valid |
| commit_tag | input | 4 | Newest tag whose predecessors are fault-free |
| exc_en | input | 1 | Fault report valid |
| exc_tag | input | 4 | Tag of the faulting instruction |
| stall | output | 1 | Log full or rollback running; writes are refused |
| busy | output | 1 | Rollback in progress |

## Verification
Directed sequences first send a fault with a tag older than everything logged, including a register written twice, so the bench can see whether the restore order is reversed. A second fault names a tag in the middle of writes that completed out of order, and the bench checks that only the younger entries are undone while the hole stays counted toward `stall`. A fault is also sent onto an empty log, one is sent while busy, and a write is sent in the same cycle as a fault. A long random run mixes windowed tags, commits and faults against a queue-based model, which catches retire timing and the trimming of the newest end.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_UNDO = 1'b1
    } hb_phase_e;

    // True when tag a is the same as or later than tag b in a window of 2**w
    function automatic logic tag_at_or_after(input logic [7:0] a,
                                             input logic [7:0] b,
                                             input int w);
        logic [7:0] diff;
        diff = a - b;
        return ~diff[w-1];
    endfunction

endpackage

// File: rtl/hb_regfile.sv
module hb_regfile #(
    parameter int NREG   = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ra0,
    input  logic [IDX_W-1:0]  ra1,
    input  logic [IDX_W-1:0]  ra2,
    output logic [DATA_W-1:0] rd0,
    output logic [DATA_W-1:0] rd1,
    output logic [DATA_W-1:0] rd2
);

    logic [DATA_W-1:0] regs_q [NREG];
    logic [DATA_W-1:0] regs_d [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            regs_d[widx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd0 = regs_q[ra0];
    assign rd1 = regs_q[ra1];
    assign rd2 = regs_q[ra2];

endmodule

// File: rtl/hb_buffer.sv
module hb_buffer
    import hb_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    parameter int PW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [IDX_W-1:0]  push_idx,
    input  logic [DATA_W-1:0] push_old,
    input  logic [TAG_W-1:0]  push_tag,
    input  logic              commit_en,
    input  logic [TAG_W-1:0]  commit_tag,
    input  logic              exc_en,
    input  logic [TAG_W-1:0]  exc_tag,
    output logic              full,
    output logic              busy,
    output logic [PW:0]       occ,
    output logic              undo_we,
    output logic [IDX_W-1:0]  undo_idx,
    output logic [DATA_W-1:0] undo_data
);

    typedef struct packed {
        logic              vld;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] old;
        logic [TAG_W-1:0]  tag;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0]  ent;
        logic [PW-1:0]     head;
        logic [PW-1:0]     tail;
        logic [PW-1:0]     ptr;
        logic [PW:0]       occ;
        hb_phase_e         phase;
        logic [TAG_W-1:0]  fault;
        logic [TAG_W-1:0]  safe_tag;
        logic              safe_vld;
        logic              trim;
    } st_t;

    st_t  s_d, s_q;
    ent_t hd, cur;
    logic pop, hit;

    always_comb begin
        s_d       = s_q;
        undo_we   = 1'b0;
        undo_idx  = '0;
        undo_data = '0;
        pop       = 1'b0;
        hit       = 1'b0;
        hd        = s_q.ent[s_q.head];
        cur       = s_q.ent[s_q.ptr];

        case (s_q.phase)
            PH_IDLE: begin
                if (exc_en) begin
                    if (s_q.occ != '0) begin
                        s_d.phase = PH_UNDO;
                        s_d.ptr   = s_q.tail - PW'(1);
                        s_d.fault = exc_tag;
                        s_d.trim  = 1'b1;
                    end
                end else begin
                    pop = (s_q.occ != '0) &&
                          (!hd.vld || (s_q.safe_vld &&
                           tag_at_or_after(8'(s_q.safe_tag), 8'(hd.tag), TAG_W)));
                    if (push) begin
                        s_d.ent[s_q.tail] = '{vld: 1'b1, idx: push_idx,
                                              old: push_old, tag: push_tag};
                        s_d.tail = s_q.tail + PW'(1);
                    end
                    if (pop) begin
                        s_d.ent[s_q.head].vld = 1'b0;
                        s_d.head = s_q.head + PW'(1);
                    end
                    s_d.occ = s_q.occ + {{PW{1'b0}}, push} - {{PW{1'b0}}, pop};
                end
            end
            PH_UNDO: begin
                hit = cur.vld && tag_at_or_after(8'(cur.tag), 8'(s_q.fault), TAG_W);
                if (hit) begin
                    undo_we   = 1'b1;
                    undo_idx  = cur.idx;
                    undo_data = cur.old;
                    s_d.ent[s_q.ptr].vld = 1'b0;
                end
                if (s_q.trim && (hit || !cur.vld)) begin
                    s_d.tail = s_q.ptr;
                    s_d.occ  = s_q.occ - (PW+1)'(1);
                end else begin
                    s_d.trim = 1'b0;
                end
                if (s_q.ptr == s_q.head) begin
                    s_d.phase = PH_IDLE;
                end
                s_d.ptr = s_q.ptr - PW'(1);
            end
            default: s_d.phase = PH_IDLE;
        endcase

        if (commit_en) begin
            s_d.safe_tag = commit_tag;
            s_d.safe_vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign full = (s_q.occ == (PW+1)'(DEPTH));
    assign busy = (s_q.phase == PH_UNDO);
    assign occ  = s_q.occ;

endmodule

// File: rtl/hist_regfile.sv
module hist_regfile #(
    parameter int NREG   = 32,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    parameter int DEPTH  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NREG)-1:0]  wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [TAG_W-1:0]         wr_tag,
    input  logic [$clog2(NREG)-1:0]  rd0_idx,
    output logic [DATA_W-1:0]        rd0_data,
    input  logic [$clog2(NREG)-1:0]  rd1_idx,
    output logic [DATA_W-1:0]        rd1_data,
    input  logic                     commit_en,
    input  logic [TAG_W-1:0]         commit_tag,
    input  logic                     exc_en,
    input  logic [TAG_W-1:0]         exc_tag,
    output logic                     stall,
    output logic                     busy
);

    localparam int IDX_W = $clog2(NREG);
    localparam int PW    = $clog2(DEPTH);

    logic              full, push;
    logic [PW:0]       occ;
    logic              undo_we;
    logic [IDX_W-1:0]  undo_idx;
    logic [DATA_W-1:0] undo_data;
    logic [DATA_W-1:0] prior;
    logic              rf_we;
    logic [IDX_W-1:0]  rf_idx;
    logic [DATA_W-1:0] rf_data;

    assign stall   = full | busy;
    assign push    = wr_en & ~stall & ~exc_en;
    assign rf_we   = undo_we | push;
    assign rf_idx  = undo_we ? undo_idx  : wr_idx;
    assign rf_data = undo_we ? undo_data : wr_data;

    hb_regfile #(.NREG(NREG), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .widx  (rf_idx),
        .wdata (rf_data),
        .ra0   (rd0_idx),
        .ra1   (rd1_idx),
        .ra2   (wr_idx),
        .rd0   (rd0_data),
        .rd1   (rd1_data),
        .rd2   (prior)
    );

    hb_buffer #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W),
                .TAG_W(TAG_W), .PW(PW)) u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_idx   (wr_idx),
        .push_old   (prior),
        .push_tag   (wr_tag),
        .commit_en  (commit_en),
        .commit_tag (commit_tag),
        .exc_en     (exc_en),
        .exc_tag    (exc_tag),
        .full       (full),
        .busy       (busy),
        .occ        (occ),
        .undo_we    (undo_we),
        .undo_idx   (undo_idx),
        .undo_data  (undo_data)
    );

endmodule

// File: rtl/hist_regfile_chk.sv
module hist_regfile_chk #(
    parameter int DEPTH = 8,
    parameter int PW    = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        exc_en,
    input logic        stall,
    input logic        busy,
    input logic [PW:0] occ
);

    p_full_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == (PW+1)'(DEPTH)) |-> stall);

    p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= (PW+1)'(DEPTH));

    p_push_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !stall && !exc_en) |=> (occ != '0));

    p_busy_stalls_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> stall);

    p_busy_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(exc_en));

    p_empty_no_undo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_en && !busy && occ == '0) |=> !busy);

    p_undo_no_grow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (occ <= $past(occ)));

endmodule

bind hist_regfile hist_regfile_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (.*);

// File: tb/hist_regfile_test.sv
module hist_regfile_test;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_tag = '0;
    logic [4:0]  rd0_idx = '0;
    logic [4:0]  rd1_idx = '0;
    logic [31:0] rd0_data, rd1_data;
    logic        commit_en = 1'b0;
    logic [3:0]  commit_tag = '0;
    logic        exc_en = 1'b0;
    logic [3:0]  exc_tag = '0;
    logic        stall, busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    hist_regfile uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_tag(wr_tag),
        .rd0_idx(rd0_idx), .rd0_data(rd0_data),
        .rd1_idx(rd1_idx), .rd1_data(rd1_data),
        .commit_en(commit_en), .commit_tag(commit_tag),
        .exc_en(exc_en), .exc_tag(exc_tag),
        .stall(stall), .busy(busy)
    );

    // ---------------- behavioural reference ----------------
    typedef struct {
        bit          v;
        int          idx;
        logic [31:0] old;
        int          tag;
    } ment_t;

    logic [31:0] mregs [32];
    ment_t       mq [$];
    int          mbusy = 0;
    int          msafe = 0;
    bit          msafe_v = 0;

    function automatic bit same_or_later(int a, int b);
        return ((a - b) & 15) < 8;
    endfunction

    initial for (int i = 0; i < 32; i++) mregs[i] = '0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (mbusy > 0) begin
                mbusy--;
            end else if (exc_en) begin
                int n;
                n = mq.size();
                if (n > 0) begin
                    for (int k = n - 1; k >= 0; k--) begin
                        if (mq[k].v && same_or_later(mq[k].tag, int'(exc_tag))) begin
                            mregs[mq[k].idx] = mq[k].old;
                            mq[k].v = 0;
                        end
                    end
                    while (mq.size() > 0 && !mq[mq.size()-1].v) void'(mq.pop_back());
                    mbusy = n;
                end
            end else begin
                bit was_full;
                ment_t e;
                was_full = (mq.size() == DEPTH);
                if (mq.size() > 0 &&
                    (!mq[0].v || (msafe_v && same_or_later(msafe, mq[0].tag))))
                    void'(mq.pop_front());
                if (wr_en && !was_full) begin
                    e.v = 1; e.idx = int'(wr_idx); e.old = mregs[wr_idx]; e.tag = int'(wr_tag);
                    mq.push_back(e);
                    mregs[wr_idx] = wr_data;
                end
            end
            if (commit_en) begin
                msafe = int'(commit_tag);
                msafe_v = 1;
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        check("R3 stall", {31'b0, stall}, {31'b0, (mq.size() == DEPTH) || (mbusy > 0)});
        check("R6 busy", {31'b0, busy}, {31'b0, mbusy > 0});
        if (mbusy == 0) begin
            check("R2 rd0", rd0_data, mregs[rd0_idx]);
            check("R2 rd1", rd1_data, mregs[rd1_idx]);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input int idx, input logic [31:0] d, input int tag);
        wr_en = 1; wr_idx = 5'(idx); wr_data = d; wr_tag = 4'(tag);
        tick();
        wr_en = 0;
    endtask

    task automatic fault(input int tag);
        exc_en = 1; exc_tag = 4'(tag);
        tick();
        exc_en = 0;
    endtask

    task automatic peek(input int idx, input logic [31:0] exp, input string req);
        rd0_idx = 5'(idx);
        #1;
        check(req, rd0_data, exp);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #2000000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int seq;
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        // R1: reset state
        check("R1 stall", {31'b0, stall}, 32'd0);
        check("R1 busy", {31'b0, busy}, 32'd0);
        peek(5, 32'd0, "R1 reg");

        // R2 / R7: out-of-order writes, all undone by an older fault
        wr(1, 32'hA1, 1);
        peek(1, 32'hA1, "R2 write visible");
        rd1_idx = 5'd1; #1; check("R2 port1", rd1_data, 32'hA1);
        wr(2, 32'hB2, 2);
        wr(1, 32'hC3, 2);
        fault(0);
        check("R6 busy rises", {31'b0, busy}, 32'd1);
        idle(2);
        check("R6 busy for N", {31'b0, busy}, 32'd1);
        tick();
        check("R6 busy ends", {31'b0, busy}, 32'd0);
        peek(1, 32'd0, "R7 newest first");
        peek(2, 32'd0, "R7 restore");

        // R8: fault in the middle keeps older entries
        wr(3, 32'd33, 5);
        wr(4, 32'd44, 7);
        wr(5, 32'd55, 6);
        fault(7);
        idle(4);
        peek(4, 32'd0, "R7 younger undone");
        peek(3, 32'd33, "R8 older kept");
        peek(5, 32'd55, "R8 older kept late");
        for (int i = 0; i < 5; i++) wr(6 + i, 32'(100 + i), 8 + i);
        check("R3 full stalls", {31'b0, stall}, 32'd1);
        wr(11, 32'hDEAD, 12);
        peek(11, 32'd0, "R4 write while stalled");

        // R5: commit retires entries
        commit_en = 1; commit_tag = 4'd12;
        tick();
        commit_en = 0;
        tick();
        check("R5 retire frees", {31'b0, stall}, 32'd0);
        idle(10);
        fault(12);
        check("R6 empty no busy", {31'b0, busy}, 32'd0);
        peek(10, 32'd104, "R5 retired not restored");

        // R4 / R9: write with fault, fault while busy
        wr(20, 32'd1, 13);
        wr(21, 32'd2, 13);
        exc_en = 1; exc_tag = 4'd13; wr_en = 1; wr_idx = 5'd22; wr_data = 32'h77; wr_tag = 4'd13;
        tick();
        wr_en = 0;
        exc_tag = 4'd0;
        tick();
        exc_en = 0;
        idle(3);
        peek(22, 32'd0, "R4 write with fault");
        peek(20, 32'd0, "R9 second fault ignored");
        peek(21, 32'd0, "R7 undo");
        check("R9 idle after", {31'b0, busy}, 32'd0);

        // random mix against the reference
        seq = 14;
        for (int c = 0; c < 4000; c++) begin
            wr_en      = ($urandom % 3) != 0;
            wr_idx     = 5'($urandom);
            wr_data    = $urandom;
            wr_tag     = 4'(seq + ($urandom % 3));
            commit_en  = ($urandom % 5) == 0;
            commit_tag = 4'(seq - 1);
            exc_en     = ($urandom % 40) == 0;
            exc_tag    = 4'(seq + ($urandom % 3));
            rd0_idx    = 5'($urandom);
            rd1_idx    = 5'($urandom);
            if (($urandom % 3) == 0) seq++;
            tick();
        end
        wr_en = 0; commit_en = 0; exc_en = 0;
        idle(12);
        for (int i = 0; i < 32; i++) peek(i, mregs[i], "R7 final state");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule